// File: doc/BRIEF.md
# Four-Lane 7:1 Serial Transmitter

This block turns a 28-bit parallel word into four serial data lanes and one framing clock lane. The word arrives with a slow pixel clock. A bit clock running at exactly seven times the pixel rate is supplied from outside. The pixel clock is sampled as a level in the bit-clock domain. The word is captured on the pixel-clock edge chosen by a select input. Once per frame the captured word is loaded into four 7-bit shift registers through a fixed, non-contiguous bit mapping, and those registers then shift once per bit clock.

A fifth lane carries a repeating 7-bit clock pattern. It is produced by the same slot counter that drives the data lanes, so a receiver can frame each 7-bit group from the edges of that lane. An active-low shutdown clears every register and forces all outputs low. After shutdown is released, the outputs stay low until the first complete captured word has been loaded.

Top module: `tx7_serializer`

## Requirements
- R1: Lane bits, listed from LSB (bit 0) to MSB (bit 6), come from these input word positions. Lane 0: 0,1,2,3,4,6,7. Lane 1: 8,9,12,13,14,15,18. Lane 2: 19,20,21,22,24,25,26. Lane 3: 27,5,10,11,16,17,23.
- R2: Within a frame, each lane sends its bit 6 first and its bit 0 last, one bit per bit clock.
- R3: With `cap_rise`=1, the word present when `pix_clk` is first sampled high is the word that gets sent.
- R4: With `cap_rise`=0, the word present when `pix_clk` is first sampled low is the word that gets sent.
- R5: Each frame is one load followed by seven shifts, so frames repeat every 7 bit clocks.
- R6: `clk_lane` sends the pattern 1100011 (first bit sent on the left) in the same 7 slots as each data frame. Its rising edge therefore always falls on the sixth slot.
- R7: While `shdn_n` is 0, all five outputs are 0 and all internal state is cleared.
- R8: After `shdn_n` rises, all outputs stay 0 until a captured word is loaded at a frame boundary, so no partial frame is ever sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bit | input | 1 | Bit clock, 7x the pixel rate |
| shdn_n | input | 1 | Active-low shutdown and asynchronous clear |
| pix_clk | input | 1 | Pixel clock phase, sampled on clk_bit |
| cap_rise | input | 1 | 1 selects capture on the rising pixel edge, 0 selects the falling edge |
| din | input | 28 | Parallel input word |
| lane_out | output | 4 | Serial data lanes |
| clk_lane | output | 1 | Serial framing clock lane |

## Verification
The bench builds the block with its default clock-lane pattern 1100011 and drives a pixel clock that is high for four bit clocks and low for three. It places different words in the high and low halves of each pixel period, so each edge-select setting picks out a word that can be told apart from the other. A bench deserializer frames on the clock lane and rebuilds each lane word. A walking-one sweep over all 28 positions then exposes every mapping entry and the bit order, and random words cover mixed patterns. Shutdown is applied mid-stream to check the forced-low outputs and the clean restart.

// File: rtl/tx7_serializer.sv
module tx7_serializer #(
  parameter logic [6:0] CLK_PATTERN = 7'b1100011
) (
  input  logic        clk_bit,
  input  logic        shdn_n,
  input  logic        pix_clk,
  input  logic        cap_rise,
  input  logic [27:0] din,
  output logic [3:0]  lane_out,
  output logic        clk_lane
);
  localparam int LANES = 4;
  localparam int SLOTS = 7;
  localparam int SW    = $clog2(SLOTS);
  localparam logic [SW-1:0] LAST = SW'(SLOTS - 1);

  localparam int MAP [0:LANES-1][0:SLOTS-1] = '{
    '{0, 1, 2, 3, 4, 6, 7},
    '{8, 9, 12, 13, 14, 15, 18},
    '{19, 20, 21, 22, 24, 25, 26},
    '{27, 5, 10, 11, 16, 17, 23}
  };

  logic                       pix_q;
  logic [27:0]                cap;
  logic                       cap_valid;
  logic [SW-1:0]              slot;
  logic [LANES-1:0][SLOTS-1:0] sreg;
  logic [LANES-1:0][SLOTS-1:0] mapped;
  logic [SLOTS-1:0]           csreg;
  logic                       armed;

  wire cap_edge  = cap_rise ? (pix_clk & ~pix_q) : (~pix_clk & pix_q);
  wire frame_end = (slot == LAST);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    for (genvar k = 0; k < SLOTS; k++) begin : g_bit
      assign mapped[l][k] = cap[MAP[l][k]];
    end
    assign lane_out[l] = shdn_n & armed & sreg[l][SLOTS-1];
  end

  assign clk_lane = shdn_n & armed & csreg[SLOTS-1];

  always_ff @(posedge clk_bit or negedge shdn_n) begin
    if (!shdn_n) begin
      pix_q     <= 1'b0;
      cap       <= '0;
      cap_valid <= 1'b0;
      slot      <= '0;
      sreg      <= '0;
      csreg     <= '0;
      armed     <= 1'b0;
    end else begin
      pix_q <= pix_clk;
      if (cap_edge) begin
        cap       <= din;
        cap_valid <= 1'b1;
      end
      slot <= frame_end ? '0 : slot + 1'b1;
      if (frame_end) begin
        sreg  <= mapped;
        csreg <= CLK_PATTERN;
        armed <= armed | cap_valid;
      end else begin
        for (int l = 0; l < LANES; l++) sreg[l] <= {sreg[l][SLOTS-2:0], 1'b0};
        csreg <= {csreg[SLOTS-2:0], 1'b0};
      end
    end
  end

  AST_FRAME_WRAP: assert property (@(posedge clk_bit) disable iff (!shdn_n)
    frame_end |=> (slot == '0)); // R5
  AST_CLK_HIGH_FIRST: assert property (@(posedge clk_bit) disable iff (!shdn_n)
    (armed && slot == '0) |-> clk_lane); // R6
  AST_CLK_LOW_MID: assert property (@(posedge clk_bit) disable iff (!shdn_n)
    (armed && slot == SW'(2)) |-> !clk_lane); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk_bit) disable iff (!shdn_n)
    !armed |-> (lane_out == '0 && !clk_lane)); // R8
  AST_SHUTDOWN_LOW: assert property (@(posedge clk_bit)
    !shdn_n |-> (lane_out == '0 && !clk_lane)); // R7
  AST_CAPTURE_HOLD: assert property (@(posedge clk_bit) disable iff (!shdn_n)
    !cap_edge |=> $stable(cap)); // R3
endmodule

// File: tb/tb_tx7_serializer.sv
module tb_tx7_serializer;
  logic        clk_bit = 0;
  logic        shdn_n = 0;
  logic        pix_clk = 0;
  logic        cap_rise = 1;
  logic [27:0] din = '0;
  logic [3:0]  lane_out;
  logic        clk_lane;

  tx7_serializer dut (.clk_bit(clk_bit), .shdn_n(shdn_n), .pix_clk(pix_clk),
                      .cap_rise(cap_rise), .din(din), .lane_out(lane_out), .clk_lane(clk_lane));

  always #5 clk_bit = ~clk_bit;

  int checks = 0, fails = 0;
  logic        pix_run = 0;
  int          phase = 0;
  logic [27:0] word_hi = '0, word_lo = '0;

  always @(negedge clk_bit) begin
    if (pix_run) begin
      pix_clk <= (phase < 4);
      din     <= (phase < 4) ? word_hi : word_lo;
      phase   <= (phase == 6) ? 0 : phase + 1;
    end else begin
      pix_clk <= 1'b0;
      phase   <= 0;
    end
  end

  logic [6:0]       hist_c = '0;
  logic [3:0][6:0]  hist_d = '0;
  logic [3:0][6:0]  rx = '0;
  int               frame_cnt = 0, cyc = 0, t_last = 0, t_prev = 0;

  always @(negedge clk_bit) begin
    logic [6:0]      nc;
    logic [3:0][6:0] nd;
    cyc++;
    nc = {hist_c[5:0], clk_lane};
    for (int l = 0; l < 4; l++) nd[l] = {hist_d[l][5:0], lane_out[l]};
    hist_c <= nc;
    hist_d <= nd;
    if (nc == 7'b1100011) begin
      rx <= nd;
      frame_cnt++;
      t_prev = t_last;
      t_last = cyc;
    end
  end

  function automatic int src_pos(int l, int k);
    int t0 [7] = '{0, 1, 2, 3, 4, 6, 7};
    int t1 [7] = '{8, 9, 12, 13, 14, 15, 18};
    int t2 [7] = '{19, 20, 21, 22, 24, 25, 26};
    int t3 [7] = '{27, 5, 10, 11, 16, 17, 23};
    case (l)
      0: return t0[k];
      1: return t1[k];
      2: return t2[k];
      default: return t3[k];
    endcase
  endfunction

  function automatic logic [6:0] exp_lane(logic [27:0] w, int l);
    logic [6:0] r;
    for (int k = 0; k < 7; k++) r[k] = w[src_pos(l, k)];
    return r;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wait_frame();
    int f = frame_cnt;
    while (frame_cnt == f) @(posedge clk_bit);
  endtask

  task automatic send_and_check(bit rise, logic [27:0] hi, logic [27:0] lo, string req);
    logic [27:0] w;
    cap_rise = rise;
    word_hi = hi;
    word_lo = lo;
    repeat (35) @(posedge clk_bit);
    wait_frame();
    @(posedge clk_bit);
    w = rise ? hi : lo;
    for (int l = 0; l < 4; l++)
      check(rx[l] == exp_lane(w, l), req, $sformatf("lane %0d", l), rx[l], exp_lane(w, l));
  endtask

  task automatic test_reset_and_release();
    int bad = 0;
    repeat (3) @(negedge clk_bit);
    check(lane_out == 0 && clk_lane == 0, "R7", "outputs in shutdown", {lane_out, clk_lane}, 0);
    @(posedge clk_bit); #2;
    shdn_n = 1;
    pix_run = 1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk_bit);
      if (lane_out != 0 || clk_lane) bad++;
    end
    check(bad == 0, "R8", "outputs before first load", bad, 0);
  endtask

  task automatic test_walking_one();
    for (int b = 0; b < 28; b++) send_and_check(1'b1, 28'd1 << b, '0, "R1");
  endtask

  task automatic test_msb_first();
    send_and_check(1'b1, 28'h0000080, '0, "R2");
    check(rx[0] == 7'b1000000, "R2", "lane0 first bit", rx[0], 7'b1000000);
    send_and_check(1'b1, 28'h0000001, '0, "R2");
    check(rx[0] == 7'b0000001, "R2", "lane0 last bit", rx[0], 7'b0000001);
  endtask

  task automatic test_rise_edge();
    for (int i = 0; i < 4; i++) send_and_check(1'b1, 28'($urandom), 28'($urandom), "R3");
    send_and_check(1'b1, 28'hFFFFFFF, 28'h0000000, "R3");
  endtask

  task automatic test_fall_edge();
    for (int i = 0; i < 4; i++) send_and_check(1'b0, 28'($urandom), 28'($urandom), "R4");
    send_and_check(1'b0, 28'h0000000, 28'hFFFFFFF, "R4");
  endtask

  task automatic test_frame_period();
    int f0;
    wait_frame();
    wait_frame();
    check(t_last - t_prev == 7, "R5", "frame spacing", t_last - t_prev, 7);
    f0 = frame_cnt;
    repeat (70) @(posedge clk_bit);
    check(frame_cnt - f0 == 10, "R6", "clock-lane frames in 70 bits", frame_cnt - f0, 10);
  endtask

  task automatic test_shutdown_mid();
    int bad = 0;
    word_hi = 28'hA5A5A5A;
    repeat (10) @(posedge clk_bit);
    #2;
    shdn_n = 0;
    pix_run = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk_bit);
      if (lane_out != 0 || clk_lane) bad++;
    end
    check(bad == 0, "R7", "outputs forced low mid-stream", bad, 0);
    test_reset_and_release();
    send_and_check(1'b1, 28'h1234567, 28'h7654321, "R7");
  endtask

  initial begin
    #2_000_000;
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    test_reset_and_release();
    test_msb_first();
    test_walking_one();
    test_rise_edge();
    test_fall_edge();
    test_frame_period();
    test_shutdown_mid();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule